// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only cache that sits between a core and a slower backing memory. The core presents a 32-bit byte address. The block returns the addressed 32-bit word together with a flag that says whether the word was already resident. Each set holds two lines. The tags of both lines are checked in the same cycle. One bit per set remembers which of the two lines was used last, and that bit picks the line to replace.

On a miss, the block asks the backing memory for the whole line at its aligned address. It takes the line back one word per beat and writes it into the chosen way. It then answers the core. While the fill runs, the core port accepts no new request. A flush input marks every line invalid in a single cycle. A flush that arrives while an access is in progress waits until that access has been answered.

The capacity and the line size are parameters. The default is 32 KB with 16-byte lines, which gives 1024 sets.

Top module: `sac_top`

## Requirements
- R1: With the default geometry, address bits [3:0] are the byte offset, bits [3:2] select the word in the line, bits [13:4] select one of 1024 sets, and bits [31:14] form the stored tag. Lines in the same set with different tags are kept apart.
- R2: After reset, and after a flush, no entry is valid. The first access to any address reports a miss. In the idle state after reset, req_ready is 1, and resp_valid and mem_req_valid are 0.
- R3: A request is accepted on an edge where req_valid and req_ready are both 1. If either way of the indexed set holds a valid matching tag, the next cycle shows resp_valid=1, resp_hit=1 and the stored word. No memory request is issued for a hit.
- R4: On a miss, mem_req_valid rises with mem_req_addr equal to the request address with its offset bits cleared. The request and its address are held until mem_req_ready is seen.
- R5: A fill takes one word per mem_rvalid beat, four beats by default. mem_req_first gives the word index of the first beat, which is the requested word index plus one, modulo four. Later beats take the following indices, wrapping, so the requested word comes last. The cycle after the last beat shows resp_valid=1, resp_hit=0 and the requested word.
- R6: req_ready stays 0 from the accepting edge until the response cycle has ended.
- R7: A miss into a set that still has an invalid way fills way 0 if it is invalid, otherwise way 1. It never evicts a valid line while an invalid way exists.
- R8: A hit makes the hit way the most recent way of its set. A fill makes the filled way the most recent. A miss into a set with both ways valid replaces the way that is not the most recent.
- R9: Filling lines A and B into one set, then hitting A, then missing on C, replaces B. A later hit on A followed by a miss on B replaces C.
- R10: A flush pulse clears all valid bits. req_ready is 0 during the flush cycle. A flush that arrives while an access is in progress takes effect before the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every line |
| req_valid | input | 1 | Core read request |
| req_addr | input | 32 | Core byte address |
| req_ready | output | 1 | Request can be accepted this cycle |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Response came from a resident line |
| resp_data | output | 32 | Requested word |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_addr | output | 32 | Line-aligned fetch address |
| mem_req_first | output | 2 | Word index of the first beat |
| mem_req_ready | input | 1 | Fetch request taken |
| mem_rvalid | input | 1 | Fill beat valid |
| mem_rdata | input | 32 | Fill beat word |

## Verification
The hardest state to reach from the ports is a full set whose most-recent bit points at a particular way. That state can only be built by a chosen order of misses and hits to addresses that share bits [13:4] but differ above bit 13. The stimulus table walks such a chain, including the case where A and B fill a set, A is touched, and C then evicts B. Each eviction is then revealed by whether a later access to the displaced line misses. A second hard case is a flush raised in the middle of a fill. This is reached by pulsing flush a few cycles after a miss has started, then proving that the line just filled is gone.

// File: rtl/sac_pkg.sv
package sac_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOOK  = 3'd1,
        ST_REQ   = 3'd2,
        ST_BEAT  = 3'd3,
        ST_DONE  = 3'd4,
        ST_FLUSH = 3'd5
    } sac_state_e;
endpackage

// File: rtl/sac_way.sv
// One way: valid bits, tag store and line store, with its own tag compare.
module sac_way #(
    parameter int SETS   = 1024,
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 18,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_vld,
    output logic              rd_hit,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    logic [SETS-1:0]   vld_d, vld_q;
    logic [TAG_W-1:0]  tag_mem [SETS];
    logic [LINE_W-1:0] dat_mem [SETS];

    always_comb begin
        vld_d = vld_q;
        if (clr_all) begin
            vld_d = '0;
        end else if (wr_en) begin
            vld_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            dat_mem[wr_idx] <= wr_line;
        end
    end

    assign rd_vld  = vld_q[rd_idx];
    assign rd_hit  = rd_vld && (tag_mem[rd_idx] == rd_tag);
    assign rd_line = dat_mem[rd_idx];
endmodule

// File: rtl/sac_mru.sv
// One most-recent bit per set.
module sac_mru #(
    parameter int SETS  = 1024,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_mru,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way
);
    logic [SETS-1:0] mru_d, mru_q;

    always_comb begin
        mru_d = mru_q;
        if (upd_en) begin
            mru_d[upd_idx] = upd_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mru_q <= '0;
        end else begin
            mru_q <= mru_d;
        end
    end

    assign rd_mru = mru_q[rd_idx];
endmodule

// File: rtl/sac_top.sv
module sac_top #(
    parameter int CACHE_BYTES = 32768,
    parameter int LINE_BYTES  = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               flush,
    input  logic                               req_valid,
    input  logic [31:0]                        req_addr,
    output logic                               req_ready,
    output logic                               resp_valid,
    output logic                               resp_hit,
    output logic [31:0]                        resp_data,
    output logic                               mem_req_valid,
    output logic [31:0]                        mem_req_addr,
    output logic [$clog2(LINE_BYTES/4)-1:0]    mem_req_first,
    input  logic                               mem_req_ready,
    input  logic                               mem_rvalid,
    input  logic [31:0]                        mem_rdata
);
    import sac_pkg::*;

    localparam int WORDS  = LINE_BYTES / 4;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SETS   = CACHE_BYTES / (LINE_BYTES * 2);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = 32 - IDX_W - OFF_W;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int LINE_W = WORDS * WORD_W;

    typedef struct packed {
        sac_state_e        st;
        logic [31:0]       addr;
        logic [WSEL_W-1:0] wsel;
        logic [WSEL_W-1:0] cnt;
        logic [LINE_W-1:0] line;
        logic              vic;
        logic              flush_pend;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [WSEL_W-1:0] crit;
    logic [1:0]        way_hit;
    logic [1:0]        way_vld;
    logic [LINE_W-1:0] way_line [2];
    logic              mru_way;
    logic              any_hit;
    logic              victim;
    logic              fill_we;
    logic              flush_run;
    logic              st_look;
    logic              upd_en;
    logic              upd_way;
    logic [LINE_W-1:0] fill_line;
    logic [LINE_W-1:0] sel_line;

    assign idx  = r_q.addr[OFF_W +: IDX_W];
    assign tag  = r_q.addr[31 -: TAG_W];
    assign crit = r_q.addr[2 +: WSEL_W];

    // Both ways are probed in the same cycle.
    for (genvar g = 0; g < 2; g++) begin : g_way
        sac_way #(
            .SETS   (SETS),
            .IDX_W  (IDX_W),
            .TAG_W  (TAG_W),
            .LINE_W (LINE_W)
        ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_all (flush_run),
            .rd_idx  (idx),
            .rd_tag  (tag),
            .rd_vld  (way_vld[g]),
            .rd_hit  (way_hit[g]),
            .rd_line (way_line[g]),
            .wr_en   (fill_we && (r_q.vic == 1'(g))),
            .wr_idx  (idx),
            .wr_tag  (tag),
            .wr_line (fill_line)
        );
    end

    sac_mru #(
        .SETS  (SETS),
        .IDX_W (IDX_W)
    ) u_mru (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (idx),
        .rd_mru  (mru_way),
        .upd_en  (upd_en),
        .upd_idx (idx),
        .upd_way (upd_way)
    );

    assign any_hit = |way_hit;

    // An empty way is used first, way 0 before way 1; otherwise the older way goes.
    always_comb begin
        if (!way_vld[0]) begin
            victim = 1'b0;
        end else if (!way_vld[1]) begin
            victim = 1'b1;
        end else begin
            victim = ~mru_way;
        end
    end

    always_comb begin
        fill_line = r_q.line;
        fill_line[r_q.wsel*WORD_W +: WORD_W] = mem_rdata;
    end

    assign st_look   = (r_q.st == ST_LOOK);
    assign flush_run = (r_q.st == ST_FLUSH);
    assign fill_we   = (r_q.st == ST_BEAT) && mem_rvalid && (r_q.cnt == WSEL_W'(WORDS - 1));
    assign upd_en    = (st_look && any_hit) || fill_we;
    assign upd_way   = st_look ? way_hit[1] : r_q.vic;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (flush || r_q.flush_pend) begin
                    r_d.st         = ST_FLUSH;
                    r_d.flush_pend = 1'b0;
                end else if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.st   = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (any_hit) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.vic = victim;
                    r_d.st  = ST_REQ;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    r_d.st   = ST_BEAT;
                    r_d.wsel = crit + 1'b1;
                    r_d.cnt  = '0;
                end
            end
            ST_BEAT: begin
                if (mem_rvalid) begin
                    r_d.line = fill_line;
                    r_d.wsel = r_q.wsel + 1'b1;
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (r_q.cnt == WSEL_W'(WORDS - 1)) begin
                        r_d.st = ST_DONE;
                    end
                end
            end
            ST_DONE:  r_d.st = ST_IDLE;
            ST_FLUSH: r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
        if (flush && (r_q.st != ST_IDLE) && (r_q.st != ST_FLUSH)) begin
            r_d.flush_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        sel_line  = st_look ? (way_hit[1] ? way_line[1] : way_line[0]) : way_line[r_q.vic];
        resp_data = sel_line[crit*WORD_W +: WORD_W];
    end

    assign req_ready     = (r_q.st == ST_IDLE) && !flush && !r_q.flush_pend;
    assign resp_valid    = (st_look && any_hit) || (r_q.st == ST_DONE);
    assign resp_hit      = st_look;
    assign mem_req_valid = (r_q.st == ST_REQ);
    assign mem_req_addr  = {r_q.addr[31:OFF_W], {OFF_W{1'b0}}};
    assign mem_req_first = crit + 1'b1;
endmodule

// File: rtl/sac_chk.sv
module sac_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        resp_valid,
    input logic        resp_hit,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        mem_rvalid,
    input logic [1:0]  way_hit,
    input logic [1:0]  way_vld,
    input logic        flush_run,
    input logic        st_look
);
    AST_NO_DUAL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_look |-> !(way_hit[0] && way_hit[1])); // R3

    AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R4

    AST_MISS_RESP_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> $past(mem_rvalid)); // R5

    AST_STALL_DURING_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R6

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_run |=> (way_vld == 2'b00)); // R10

    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_run |-> !req_ready); // R10
endmodule

bind sac_top sac_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rvalid    (mem_rvalid),
    .way_hit       (way_hit),
    .way_vld       (way_vld),
    .flush_run     (flush_run),
    .st_look       (st_look)
);

// File: tb/sac_top_tb.sv
module sac_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        resp_valid;
    logic        resp_hit;
    logic [31:0] resp_data;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic [1:0]  mem_req_first;
    logic        mem_req_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    int mem_reqs = 0;
    logic [31:0] last_line = '0;
    logic [1:0]  last_first = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sac_top u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_ready     (req_ready),
        .resp_valid    (resp_valid),
        .resp_hit      (resp_hit),
        .resp_data     (resp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_first (mem_req_first),
        .mem_req_ready (mem_req_ready),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return ((a & ~32'h3) * 32'h9E3779B1) ^ 32'h13579BDF;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Backing memory: takes a fetch, then returns four beats in wrap order.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                mem_reqs++;
                last_line  = mem_req_addr;
                last_first = mem_req_first;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int k = 0; k < WORDS; k++) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem_word(last_line + 32'(4 * ((int'(last_first) + k) % WORDS)));
                    @(negedge clk);
                end
                mem_rvalid = 1'b0;
            end
        end
    end

    task automatic access(input logic [31:0] a, input logic exp_hit, input string req);
        int waited;
        bit stall_bad;
        int reqs_before;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = a;
        reqs_before = mem_reqs;
        @(negedge clk);
        req_valid = 1'b0;
        stall_bad = 1'b0;
        waited    = 0;
        while (!resp_valid && waited < 100) begin
            if (req_ready) stall_bad = 1'b1;
            @(negedge clk);
            waited++;
        end
        if (req_ready) stall_bad = 1'b1;
        chk(resp_valid, {req, " response present"}, 32'(resp_valid), 32'd1);
        chk(resp_hit == exp_hit, {req, " hit flag"}, 32'(resp_hit), 32'(exp_hit));
        chk(resp_data == mem_word(a), {req, " data"}, resp_data, mem_word(a));
        chk(!stall_bad, "R6 ready low while busy", 32'(stall_bad), 32'd0);
        if (exp_hit) begin
            chk(mem_reqs == reqs_before, "R3 no fetch on hit", 32'(mem_reqs - reqs_before), 32'd0);
        end else begin
            chk(last_line == (a & ~32'hF), "R4 aligned fetch", last_line, a & ~32'hF);
            chk(last_first == 2'(a[3:2] + 2'd1), "R5 critical word last", 32'(last_first), 32'(2'(a[3:2] + 2'd1)));
        end
    endtask

    // {expected hit, address}; set 0x12 is shared by tags 0, 1 and 2.
    localparam logic [32:0] VEC [13] = '{
        {1'b0, 32'h0000_0124},  // R2 first access misses
        {1'b0, 32'h0000_4128},  // R7 second way filled
        {1'b1, 32'h0000_012C},  // R3 A hit, A most recent
        {1'b1, 32'h0000_4120},  // R7 B still resident
        {1'b1, 32'h0000_0124},  // R9 A touched
        {1'b0, 32'h0000_8124},  // R9 C evicts B
        {1'b1, 32'h0000_0128},  // R9 A survived
        {1'b0, 32'h0000_4124},  // R9 B gone, evicts C
        {1'b0, 32'h0000_8120},  // R8 C gone, evicts A
        {1'b1, 32'h0000_412C},  // R8 B survived
        {1'b0, 32'h0000_0200},  // R5 another set, word 0
        {1'b1, 32'h0000_0204},  // R5 word 1 filled
        {1'b1, 32'h0000_020C}   // R5 word 3 filled
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 reset ready", 32'(req_ready), 32'd1);
        chk(resp_valid == 1'b0, "R2 reset no response", 32'(resp_valid), 32'd0);
        chk(mem_req_valid == 1'b0, "R2 reset no fetch", 32'(mem_req_valid), 32'd0);

        for (int i = 0; i < 13; i++) begin
            access(VEC[i][31:0], VEC[i][32], $sformatf("R8/R9 vec%0d", i));
        end

        // R1: top set, top tag and tag zero share set 1023 in two ways.
        access(32'hFFFF_FFFC, 1'b0, "R1 high tag miss");
        access(32'h0000_3FF4, 1'b0, "R1 low tag same set miss");
        access(32'hFFFF_FFF0, 1'b1, "R1 high tag hit");
        access(32'h0000_3FF8, 1'b1, "R1 low tag hit");
        access(32'h0000_0010, 1'b0, "R1 set 1 miss");

        // R10: flush from idle.
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(req_ready == 1'b0, "R10 ready low in flush", 32'(req_ready), 32'd0);
        access(32'h0000_412C, 1'b0, "R10 miss after flush");
        access(32'hFFFF_FFF0, 1'b0, "R10 other set flushed");

        // R10: flush raised in the middle of a fill is deferred.
        fork
            access(32'h0000_0500, 1'b0, "R10 fill during flush");
            begin
                repeat (4) @(negedge clk);
                flush = 1'b1;
                @(negedge clk);
                flush = 1'b0;
            end
        join
        access(32'h0000_0504, 1'b0, "R10 deferred flush applied");
        access(32'h0000_0508, 1'b1, "R3 hit after refill");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule